// File: doc/BRIEF.md
# NAND Flash Operation Engine

The engine carries out one NAND bus operation per start request and then raises a done flag. Software loads a command byte, an address byte and a configuration word through a small register port. It then writes a one-hot operation code to the control register. That single write both picks the operation and launches it. The four operations are: a command cycle, an address cycle, a data-input burst from an internal buffer, and a data-output burst into that buffer. A data-output burst is a page read, a device ID read or a status read. While an operation runs, the done bit in the same control register reads zero. Software polls that bit.

The engine drives command-latch and address-latch enables, active-low write and read strobes and an active-low chip enable toward an 8- or 16-bit device. Before a page read it waits on the ready/busy line. Each strobe is low for a fixed number of clocks, with guard cycles before and after it. Error-correction results come from outside the block. They are captured into a status register when a page read completes, with separate fields for the main area and the spare area. Software reaches the internal buffer through a pointer register and a data window.

Top module: `nand_op_engine`

## Requirements
- R1: After reset the control register reads done (bit 15) as 1. The chip enable, write strobe and read strobe are high, the latch enables are low and the interrupt output is low.
- R2: An accepted start write clears done from the next cycle until the operation completes. A start write while done is 0 is ignored, and the control readback (bits 3:0, one-hot op) keeps the running operation.
- R3: Control code 4'b0001 in bits 3:0 produces exactly one write-strobe pulse with the command latch high and the address latch low. The pulse lasts PULSE_CYC clocks, and dq_o[7:0] carries the command register while dq_o[15:8] is 0.
- R4: Control code 4'b0010 produces one write-strobe pulse of PULSE_CYC clocks with the address latch high, the command latch low and the address byte on dq_o[7:0].
- R5: Control code 4'b0100 sends one page from the buffer, one write-strobe pulse per beat, with both latches low. On an 8-bit bus, byte k is taken from word k/2: from the low half when k is even in little-endian mode, and from the opposite half in big-endian mode. On a 16-bit bus, beat k carries word k.
- R6: Control code 4'b1000 with sub-type 0 in bits 5:4 (page read) issues no read strobe until rb_i is high. It then reads one page, with one beat per byte on an 8-bit bus and one per halfword on a 16-bit bus, and stores the data with the same lane placement as R5.
- R7: Sub-type 1 (ID read) issues ID_BEATS read strobes and sub-type 2 (status read) issues one read strobe. Neither waits on rb_i. The data are stored from buffer word 0 upward.
- R8: Configuration bit 31 selects a 16-bit bus and bit 30 selects 2048-byte pages instead of 512-byte pages. When small_buf_i is high, a written 1 in bit 30 is dropped and reads back 0.
- R9: When a page read completes, the ECC status register captures ecc_main_i into bits 3:2 and ecc_spare_i into bits 1:0 if configuration bit 3 (ECC enable) is set. If that bit is clear, the register captures 0.
- R10: Writing configuration bit 0 aborts any operation. Done reads 1 the next cycle and no further strobe is issued.
- R11: irq_o goes high when an operation completes while configuration bit 1 (interrupt disable) is 0. It is cleared by the next accepted start or by a soft reset, and it stays low when interrupts are disabled.
- R12: A control write whose bits 3:0 are not one-hot, or a data-output code with sub-type 3, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select (0 cmd, 1 addr, 2 cfg, 3 ctrl, 4 ecc, 5 pointer, 6 data) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| small_buf_i | input | 1 | Buffer is limited to 1 KB |
| ecc_main_i | input | 2 | Main-area ECC result (1 corrected, 2 uncorrectable) |
| ecc_spare_i | input | 2 | Spare-area ECC result (1 corrected, 2 uncorrectable) |
| irq_o | output | 1 | Completion interrupt |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| ce_no | output | 1 | Chip enable, active low |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| dq_o | output | 16 | Data bus out |
| dq_oe_o | output | 1 | Data bus drive enable |
| dq_i | input | 16 | Data bus in |
| rb_i | input | 1 | Device ready (high) / busy (low) |

## Verification
A wrong sequencer state becomes visible at the strobes within one beat of four clocks. It shows up as a pulse with the wrong length, a pulse count that differs from the page or ID length, or a read strobe issued while rb_i is low. A stale done bit or a stuck operation code shows up in the next control-register read: done stays 0 forever, or a start that should have been ignored replaces the running operation. A wrong beat counter or lane select shows only after the burst ends, when the buffer words read back through the data window are in the wrong place or the wrong byte order.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;
  typedef enum logic [1:0] {OP_CMD = 2'd0, OP_ADDR = 2'd1, OP_DIN = 2'd2, OP_DOUT = 2'd3} op_e;
  typedef enum logic [1:0] {OT_PAGE = 2'd0, OT_ID = 2'd1, OT_STAT = 2'd2} otype_e;

  localparam logic [2:0] RA_CMD  = 3'd0;
  localparam logic [2:0] RA_ADDR = 3'd1;
  localparam logic [2:0] RA_CFG  = 3'd2;
  localparam logic [2:0] RA_CTRL = 3'd3;
  localparam logic [2:0] RA_ECC  = 3'd4;
  localparam logic [2:0] RA_PTR  = 3'd5;
  localparam logic [2:0] RA_DATA = 3'd6;

  typedef struct packed {
    logic bus16;
    logic page2k;
    logic ecc_en;
    logic big_end;
    logic int_dis;
  } cfg_t;
endpackage

// File: rtl/nand_eng_buf.sv
module nand_eng_buf #(
  parameter int WORDS = 1024,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          h_we_i,
  input  logic [AW-1:0] h_idx_i,
  input  logic [15:0]   h_wd_i,
  output logic [15:0]   h_rd_o,
  input  logic          s_we_i,
  input  logic [1:0]    s_be_i,
  input  logic [AW-1:0] s_idx_i,
  input  logic [15:0]   s_wd_i,
  output logic [15:0]   s_rd_o
);
  logic [15:0] mem [WORDS];

  // sequencer wins; host writes are already gated while busy
  always_ff @(posedge clk_i) begin
    if (s_we_i) begin
      if (s_be_i[0]) mem[s_idx_i][7:0]  <= s_wd_i[7:0];
      if (s_be_i[1]) mem[s_idx_i][15:8] <= s_wd_i[15:8];
    end else if (h_we_i) begin
      mem[h_idx_i] <= h_wd_i;
    end
  end

  assign h_rd_o = mem[h_idx_i];
  assign s_rd_o = mem[s_idx_i];
endmodule

// File: rtl/nand_eng_regs.sv
module nand_eng_regs
  import nand_eng_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          small_buf_i,
  input  logic [1:0]    ecc_main_i,
  input  logic [1:0]    ecc_spare_i,
  input  logic          done_i,
  input  logic          fin_i,
  input  logic [15:0]   buf_rd_i,
  output logic [7:0]    cmd_o,
  output logic [7:0]    addr_o,
  output cfg_t          cfg_o,
  output logic          start_o,
  output op_e           op_o,
  output otype_e        otype_o,
  output logic          abort_o,
  output logic          irq_o,
  output logic          hbuf_we_o,
  output logic [AW-1:0] hbuf_idx_o
);
  logic [3:0]    code;
  logic [1:0]    sub;
  logic          code_ok, sub_ok;
  logic [7:0]    cmd_q, addr_q;
  cfg_t          cfg_q;
  op_e           op_q;
  otype_e        otype_q;
  logic [3:0]    ecc_q;
  logic          irq_q;
  logic [AW-1:0] ptr_q;
  logic [3:0]    op_hot;
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign code    = reg_wdata_i[3:0];
  assign sub     = reg_wdata_i[5:4];
  assign code_ok = $onehot(code);
  assign sub_ok  = !(code[3] && sub == 2'b11);
  assign start_o = reg_we_i && reg_addr_i == RA_CTRL && done_i && code_ok && sub_ok;
  assign abort_o = reg_we_i && reg_addr_i == RA_CFG && reg_wdata_i[0];

  always_comb begin
    case (code)
      4'b0001: op_o = OP_CMD;
      4'b0010: op_o = OP_ADDR;
      4'b0100: op_o = OP_DIN;
      default: op_o = OP_DOUT;
    endcase
    otype_o = (code == 4'b1000) ? otype_e'(sub) : OT_PAGE;
  end

  assign hbuf_we_o  = reg_we_i && reg_addr_i == RA_DATA && done_i;
  assign hbuf_idx_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      cfg_q   <= '0;
      op_q    <= OP_CMD;
      otype_q <= OT_PAGE;
      ecc_q   <= '0;
      irq_q   <= 1'b0;
      ptr_q   <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == RA_CMD)  cmd_q  <= reg_wdata_i[7:0];
      if (reg_we_i && reg_addr_i == RA_ADDR) addr_q <= reg_wdata_i[7:0];
      if (reg_we_i && reg_addr_i == RA_CFG) begin
        cfg_q.bus16   <= reg_wdata_i[31];
        cfg_q.page2k  <= reg_wdata_i[30] & ~small_buf_i;
        cfg_q.ecc_en  <= reg_wdata_i[3];
        cfg_q.big_end <= reg_wdata_i[2];
        cfg_q.int_dis <= reg_wdata_i[1];
      end
      if (start_o) begin
        op_q    <= op_o;
        otype_q <= otype_o;
      end
      if (fin_i && op_q == OP_DOUT && otype_q == OT_PAGE)
        ecc_q <= cfg_q.ecc_en ? {ecc_main_i, ecc_spare_i} : 4'h0;
      if (start_o || abort_o) irq_q <= 1'b0;
      else if (fin_i && !cfg_q.int_dis) irq_q <= 1'b1;
      if (reg_we_i && reg_addr_i == RA_PTR) ptr_q <= reg_wdata_i[AW-1:0];
      else if (hbuf_we_o) ptr_q <= ptr_q + 1'b1;
    end
  end

  always_comb begin
    op_hot = 4'b0001 << op_q;
    case (reg_addr_i)
      RA_CMD:  reg_rdata_o = {24'h0, cmd_q};
      RA_ADDR: reg_rdata_o = {24'h0, addr_q};
      RA_CFG:  reg_rdata_o = {cfg_q.bus16, cfg_q.page2k, 26'h0, cfg_q.ecc_en,
                              cfg_q.big_end, cfg_q.int_dis, 1'b0};
      RA_CTRL: reg_rdata_o = {16'h0, done_i, 9'h0, otype_q, op_hot};
      RA_ECC:  reg_rdata_o = {28'h0, ecc_q};
      RA_PTR:  reg_rdata_o = {{(32-AW){1'b0}}, ptr_q};
      RA_DATA: reg_rdata_o = {16'h0, buf_rd_i};
      default: reg_rdata_o = 32'h0;
    endcase
  end

  assign cmd_o  = cmd_q;
  assign addr_o = addr_q;
  assign cfg_o  = cfg_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/nand_eng_seq.sv
module nand_eng_seq
  import nand_eng_pkg::*;
#(
  parameter int PULSE_CYC  = 2,
  parameter int GAP_CYC    = 1,
  parameter int ID_BEATS   = 4,
  parameter int SMALL_PAGE = 512,
  parameter int LARGE_PAGE = 2048,
  parameter int AW         = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  op_e           op_i,
  input  otype_e        otype_i,
  input  logic          abort_i,
  input  cfg_t          cfg_i,
  input  logic [7:0]    cmd_i,
  input  logic [7:0]    addr_i,
  output logic          done_o,
  output logic          fin_o,
  output logic          cle_o,
  output logic          ale_o,
  output logic          ce_no,
  output logic          we_no,
  output logic          re_no,
  output logic [15:0]   dq_o,
  output logic          dq_oe_o,
  input  logic [15:0]   dq_i,
  input  logic          rb_i,
  input  logic [15:0]   buf_rd_i,
  output logic          buf_we_o,
  output logic [1:0]    buf_be_o,
  output logic [AW-1:0] buf_idx_o,
  output logic [15:0]   buf_wd_o
);
  localparam int BW = AW + 1;
  localparam int CMAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] PUL_LAST = CW'(PULSE_CYC - 1);
  localparam logic [BW-1:0] LAST_S8  = BW'(SMALL_PAGE - 1);
  localparam logic [BW-1:0] LAST_S16 = BW'(SMALL_PAGE / 2 - 1);
  localparam logic [BW-1:0] LAST_L8  = BW'(LARGE_PAGE - 1);
  localparam logic [BW-1:0] LAST_L16 = BW'(LARGE_PAGE / 2 - 1);
  localparam logic [BW-1:0] LAST_ID  = BW'(ID_BEATS - 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SET, S_PUL, S_HOLD} st_e;

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] beat_q, last_q, last_n, page_last;
  op_e           op_q;
  logic          done_q;
  logic          busy, lane, beat_end;

  always_comb begin
    case ({cfg_i.page2k, cfg_i.bus16})
      2'b00:   page_last = LAST_S8;
      2'b01:   page_last = LAST_S16;
      2'b10:   page_last = LAST_L8;
      default: page_last = LAST_L16;
    endcase
    case (op_i)
      OP_DIN:  last_n = page_last;
      OP_DOUT: last_n = (otype_i == OT_PAGE) ? page_last :
                        (otype_i == OT_ID) ? LAST_ID : '0;
      default: last_n = '0;
    endcase
  end

  assign beat_end = st_q == S_HOLD && cnt_q == GAP_LAST;
  assign fin_o    = beat_end && beat_q == last_q && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      beat_q <= '0;
      last_q <= '0;
      op_q   <= OP_CMD;
      done_q <= 1'b1;
    end else if (abort_i) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          op_q   <= op_i;
          last_q <= last_n;
          beat_q <= '0;
          cnt_q  <= '0;
          done_q <= 1'b0;
          st_q   <= (op_i == OP_DOUT && otype_i == OT_PAGE) ? S_WAIT : S_SET;
        end
        S_WAIT: if (rb_i) st_q <= S_SET;
        S_SET: begin
          cnt_q <= (cnt_q == GAP_LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == GAP_LAST) st_q <= S_PUL;
        end
        S_PUL: begin
          cnt_q <= (cnt_q == PUL_LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == PUL_LAST) st_q <= S_HOLD;
        end
        S_HOLD: begin
          cnt_q <= beat_end ? '0 : cnt_q + 1'b1;
          if (beat_end) begin
            if (beat_q == last_q) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              beat_q <= beat_q + 1'b1;
              st_q   <= S_SET;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy    = st_q != S_IDLE;
  assign done_o  = done_q;
  assign ce_no   = !busy;
  assign cle_o   = busy && op_q == OP_CMD;
  assign ale_o   = busy && op_q == OP_ADDR;
  assign we_no   = !(st_q == S_PUL && op_q != OP_DOUT);
  assign re_no   = !(st_q == S_PUL && op_q == OP_DOUT);
  assign dq_oe_o = busy && op_q != OP_DOUT;

  // byte lane within a buffer word for 8-bit beats
  assign lane      = beat_q[0] ^ cfg_i.big_end;
  assign buf_idx_o = cfg_i.bus16 ? beat_q[AW-1:0] : beat_q[AW:1];

  always_comb begin
    case (op_q)
      OP_CMD:  dq_o = {8'h0, cmd_i};
      OP_ADDR: dq_o = {8'h0, addr_i};
      OP_DIN:  dq_o = cfg_i.bus16 ? buf_rd_i :
                      {8'h0, lane ? buf_rd_i[15:8] : buf_rd_i[7:0]};
      default: dq_o = 16'h0;
    endcase
  end

  assign buf_we_o = st_q == S_PUL && cnt_q == PUL_LAST && op_q == OP_DOUT;
  assign buf_be_o = cfg_i.bus16 ? 2'b11 : (lane ? 2'b10 : 2'b01);
  assign buf_wd_o = cfg_i.bus16 ? dq_i : {dq_i[7:0], dq_i[7:0]};
endmodule

// File: rtl/nand_op_engine.sv
module nand_op_engine
  import nand_eng_pkg::*;
#(
  parameter int PULSE_CYC  = 2,
  parameter int GAP_CYC    = 1,
  parameter int ID_BEATS   = 4,
  parameter int SMALL_PAGE = 512,
  parameter int LARGE_PAGE = 2048,
  parameter int BUF_BYTES  = 2048
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        small_buf_i,
  input  logic [1:0]  ecc_main_i,
  input  logic [1:0]  ecc_spare_i,
  output logic        irq_o,
  output logic        cle_o,
  output logic        ale_o,
  output logic        ce_no,
  output logic        we_no,
  output logic        re_no,
  output logic [15:0] dq_o,
  output logic        dq_oe_o,
  input  logic [15:0] dq_i,
  input  logic        rb_i
);
  localparam int BUF_WORDS = BUF_BYTES / 2;
  localparam int AW = $clog2(BUF_WORDS);

  logic          done, fin, start, abort;
  op_e           op;
  otype_e        otype;
  cfg_t          cfg;
  logic [7:0]    cmd, addr;
  logic          hbuf_we;
  logic [AW-1:0] hbuf_idx, sbuf_idx;
  logic [15:0]   hbuf_rd, sbuf_rd, sbuf_wd;
  logic          sbuf_we;
  logic [1:0]    sbuf_be;

  nand_eng_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .small_buf_i, .ecc_main_i, .ecc_spare_i,
    .done_i(done), .fin_i(fin), .buf_rd_i(hbuf_rd),
    .cmd_o(cmd), .addr_o(addr), .cfg_o(cfg), .start_o(start), .op_o(op),
    .otype_o(otype), .abort_o(abort), .irq_o,
    .hbuf_we_o(hbuf_we), .hbuf_idx_o(hbuf_idx)
  );

  nand_eng_seq #(
    .PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC), .ID_BEATS(ID_BEATS),
    .SMALL_PAGE(SMALL_PAGE), .LARGE_PAGE(LARGE_PAGE), .AW(AW)
  ) u_seq (
    .clk_i, .rst_ni, .start_i(start), .op_i(op), .otype_i(otype),
    .abort_i(abort), .cfg_i(cfg), .cmd_i(cmd), .addr_i(addr),
    .done_o(done), .fin_o(fin), .cle_o, .ale_o, .ce_no, .we_no, .re_no,
    .dq_o, .dq_oe_o, .dq_i, .rb_i,
    .buf_rd_i(sbuf_rd), .buf_we_o(sbuf_we), .buf_be_o(sbuf_be),
    .buf_idx_o(sbuf_idx), .buf_wd_o(sbuf_wd)
  );

  nand_eng_buf #(.WORDS(BUF_WORDS), .AW(AW)) u_buf (
    .clk_i,
    .h_we_i(hbuf_we), .h_idx_i(hbuf_idx), .h_wd_i(reg_wdata_i[15:0]), .h_rd_o(hbuf_rd),
    .s_we_i(sbuf_we), .s_be_i(sbuf_be), .s_idx_i(sbuf_idx), .s_wd_i(sbuf_wd),
    .s_rd_o(sbuf_rd)
  );
endmodule

// File: rtl/nand_op_engine_chk.sv
module nand_op_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [2:0]  reg_addr_i,
  input logic        soft_bit_i,
  input logic        cle_o,
  input logic        ale_o,
  input logic        ce_no,
  input logic        we_no,
  input logic        re_no,
  input logic [15:0] dq_o,
  input logic        irq_o,
  input logic        done_i
);
  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));

  assert_latch_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));

  assert_done_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (ce_no && we_no && re_no));

  assert_dq_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no && !$past(we_no)) |-> $stable(dq_o));

  assert_soft_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd2 && soft_bit_i) |=> (done_i && ce_no));

  assert_irq_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> done_i);
endmodule

bind nand_op_engine nand_op_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .soft_bit_i(reg_wdata_i[0]), .cle_o(cle_o), .ale_o(ale_o), .ce_no(ce_no),
  .we_no(we_no), .re_no(re_no), .dq_o(dq_o), .irq_o(irq_o), .done_i(done)
);

// File: tb/nand_op_engine_test.sv
module nand_op_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE_CYC  = 2;
  localparam int LOGN = 2048;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        small_buf = 1'b0;
  logic [1:0]  ecc_main = 2'd0, ecc_spare = 2'd0;
  logic        irq, cle, ale, ce_n, we_n, re_n, dq_oe, rb = 1'b1;
  logic [15:0] dq_out, dq_in, dev_base = 16'h0;

  int checks = 0, fails = 0, n_we = 0, n_re = 0, we_len = 0, re_len = 0;
  logic prev_we = 1'b1, prev_re = 1'b1, finished = 1'b0;
  logic [15:0] log_dq [LOGN];
  logic        log_cle [LOGN];
  logic        log_ale [LOGN];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_op_engine #(.PULSE_CYC(PULSE_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .small_buf_i(small_buf),
    .ecc_main_i(ecc_main), .ecc_spare_i(ecc_spare), .irq_o(irq),
    .cle_o(cle), .ale_o(ale), .ce_no(ce_n), .we_no(we_n), .re_no(re_n),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .dq_i(dq_in), .rb_i(rb)
  );

  // device model: each read strobe returns base + strobe index
  assign dq_in = dev_base + 16'(n_re) - 16'd1;

  always @(negedge clk) begin
    if (!we_n) begin
      if (prev_we) begin
        if (n_we < LOGN) begin
          log_dq[n_we] = dq_out; log_cle[n_we] = cle; log_ale[n_we] = ale;
        end
        n_we = n_we + 1; we_len = 1;
      end else we_len = we_len + 1;
    end
    if (!re_n) begin
      if (prev_re) begin n_re = n_re + 1; re_len = 1; end
      else re_len = re_len + 1;
    end
    prev_we = we_n; prev_re = re_n;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      reg_addr = 3'd3;
      #1 if (reg_rdata[15]) break;
    end
  endtask

  task automatic clr_log();
    n_we = 0; n_re = 0;
  endtask

  task automatic rd_buf(input int idx, output logic [31:0] v);
    wr(3'd5, idx);
    rd(3'd6, v);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // {is_addr, byte}
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'h70}, {1'b1, 8'h00}, {1'b0, 8'hFF},
    {1'b1, 8'hA5}, {1'b0, 8'h90}, {1'b1, 8'h3C}
  };

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    int bad;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(3'd3, v);
    chk(v[15] == 1'b1, "R1 done after reset", v, 32'h8000);
    chk({ce_n, we_n, re_n, cle, ale, irq} == 6'b111000, "R1 bus idle after reset",
        {ce_n, we_n, re_n, cle, ale, irq}, 6'b111000);

    // R3/R4 table: 16-bit bus, interrupts disabled
    wr(3'd2, 32'h8000_0002);
    for (int i = 0; i < 6; i++) begin
      logic is_addr;
      logic [7:0] b;
      is_addr = VEC[i][8]; b = VEC[i][7:0];
      wr(is_addr ? 3'd1 : 3'd0, {24'h0, b});
      clr_log();
      wr(3'd3, is_addr ? 32'h2 : 32'h1);
      rd(3'd3, v);
      chk(v[15] == 1'b0, "R2 done cleared by start", v, 32'h0);
      wait_done();
      chk(n_we == 1, is_addr ? "R4 one pulse" : "R3 one pulse", n_we, 1);
      chk(log_dq[0] == {8'h0, b}, is_addr ? "R4 bus byte" : "R3 bus byte", log_dq[0], {8'h0, b});
      chk(log_cle[0] == !is_addr && log_ale[0] == is_addr, is_addr ? "R4 latches" : "R3 latches",
          {log_cle[0], log_ale[0]}, {!is_addr, is_addr});
      chk(we_len == PULSE_CYC, "R3 pulse width", we_len, PULSE_CYC);
    end

    // R12 bad codes
    clr_log();
    wr(3'd3, 32'h3);
    wr(3'd3, 32'h38);
    repeat (8) @(negedge clk);
    rd(3'd3, v);
    chk(n_we == 0 && n_re == 0 && v[3:0] == 4'b0010, "R12 invalid codes ignored", {n_we[15:0], n_re[15:0]}, 0);

    // R7 status read, 8-bit LE, interrupts on; R11
    wr(3'd2, 32'h0);
    clr_log(); dev_base = 16'h00C0;
    wr(3'd3, 32'h28);
    wait_done();
    chk(n_re == 1, "R7 status one strobe", n_re, 1);
    rd_buf(0, v);
    chk(v[7:0] == 8'hC0, "R7 status stored", v[7:0], 8'hC0);
    chk(irq == 1'b1, "R11 irq on completion", irq, 1);

    // R7 ID read with rb low, 8-bit BE, interrupts disabled
    wr(3'd2, 32'h6);
    rb = 1'b0; clr_log(); dev_base = 16'h00A0;
    wr(3'd3, 32'h18);
    wait_done();
    chk(n_re == 4, "R7 ID strobes without rb", n_re, 4);
    rd_buf(0, v);
    chk(v[15:0] == 16'hA0A1, "R7 ID word0 big-endian", v, 16'hA0A1);
    rd_buf(1, v);
    chk(v[15:0] == 16'hA2A3, "R7 ID word1 big-endian", v, 16'hA2A3);
    chk(irq == 1'b0, "R11 irq masked", irq, 0);

    // R6 page read 16-bit with ECC; R2 ignored start; R9
    wr(3'd2, 32'h8000_0008);
    ecc_main = 2'd2; ecc_spare = 2'd1;
    clr_log(); dev_base = 16'h1000;
    wr(3'd3, 32'h8);
    repeat (20) @(negedge clk);
    rd(3'd3, v);
    chk(n_re == 0 && v[15] == 1'b0, "R6 no strobe while busy", n_re, 0);
    wr(3'd3, 32'h1);
    repeat (6) @(negedge clk);
    rd(3'd3, v);
    chk(n_we == 0 && v[3:0] == 4'b1000, "R2 start ignored while busy", v[3:0], 4'b1000);
    rb = 1'b1;
    wait_done();
    chk(n_re == 256, "R6 page beats 16-bit", n_re, 256);
    chk(re_len == PULSE_CYC, "R6 read pulse width", re_len, PULSE_CYC);
    rd_buf(0, v);
    chk(v[15:0] == 16'h1000, "R6 word0", v, 16'h1000);
    rd_buf(255, v);
    chk(v[15:0] == 16'h10FF, "R6 word255", v, 16'h10FF);
    rd(3'd4, v);
    chk(v[3:0] == 4'b1001, "R9 ECC captured", v, 4'b1001);

    // R6/R9 page read 8-bit LE, ECC disabled
    wr(3'd2, 32'h0);
    clr_log(); dev_base = 16'h0010;
    wr(3'd3, 32'h8);
    wait_done();
    chk(n_re == 512, "R6 page beats 8-bit", n_re, 512);
    rd_buf(0, v);
    chk(v[15:0] == 16'h1110, "R6 8-bit packing word0", v, 16'h1110);
    rd_buf(255, v);
    chk(v[15:0] == 16'h0F0E, "R6 8-bit packing word255", v, 16'h0F0E);
    rd(3'd4, v);
    chk(v[3:0] == 4'h0, "R9 ECC cleared when disabled", v, 0);

    // R5 data input, 8-bit LE then 16-bit
    wr(3'd5, 0);
    for (int i = 0; i < 256; i++) wr(3'd6, {16'h0, 8'(2*i+1), 8'(2*i)});
    clr_log();
    wr(3'd3, 32'h4);
    wait_done();
    chk(n_we == 512, "R5 beats 8-bit", n_we, 512);
    bad = 0;
    for (int k = 0; k < 512; k++)
      if (log_dq[k] !== {8'h0, 8'(k)} || log_cle[k] || log_ale[k]) bad++;
    chk(bad == 0, "R5 8-bit byte order", bad, 0);
    wr(3'd2, 32'h8000_0000);
    clr_log();
    wr(3'd3, 32'h4);
    wait_done();
    chk(n_we == 256, "R5 beats 16-bit", n_we, 256);
    bad = 0;
    for (int k = 0; k < 256; k++)
      if (log_dq[k] !== {8'(2*k+1), 8'(2*k)}) bad++;
    chk(bad == 0, "R5 16-bit words", bad, 0);

    // R8 page size and small-buffer rejection
    small_buf = 1'b1;
    wr(3'd2, 32'hC000_0000);
    rd(3'd2, v);
    chk(v[31:30] == 2'b10, "R8 2K page rejected with 1K buffer", v[31:30], 2'b10);
    small_buf = 1'b0;
    wr(3'd2, 32'hC000_0000);
    rd(3'd2, v);
    chk(v[31:30] == 2'b11, "R8 config readback", v[31:30], 2'b11);
    clr_log();
    wr(3'd3, 32'h4);
    wait_done();
    chk(n_we == 1024, "R8 2K page 16-bit beats", n_we, 1024);

    // R10 soft reset abort
    wr(3'd2, 32'h0);
    rb = 1'b0; clr_log();
    wr(3'd3, 32'h8);
    repeat (5) @(negedge clk);
    wr(3'd2, 32'h1);
    rd(3'd3, v);
    chk(v[15] == 1'b1 && ce_n == 1'b1, "R10 abort restores done", {v[15], ce_n}, 2'b11);
    rb = 1'b1;
    repeat (20) @(negedge clk);
    chk(n_re == 0, "R10 no strobe after abort", n_re, 0);

    summary();
  end
endmodule